// File: doc/BRIEF.md
# Configurable Generic Logic Block

This block models one programmable logic cell of a small programmable-logic fabric. Eighteen input signals enter a programmable AND plane. The plane holds twenty shared product terms plus three dedicated terms. Four macrocells combine those terms into four outputs. A macrocell takes one of two logic paths. The fast path ORs four of its own terms. The wide path gathers whole five-term groups, which can be stolen from neighbouring macrocells, and then applies a programmable inversion. Each output is either combinatorial or comes from a D register.

All registers in the block share one clock. That clock is either one of three global clock lines or a product term computed inside the block. The clock source is observed on the system clock, and a register loads on a rising edge of the chosen source. One dedicated term clears the registers. A second dedicated term produces an output-enable signal for the downstream I/O cells. An active-low global reset input also clears the registers. The outputs are meant to return to the routing fabric as inputs for any block.

All behaviour comes from configuration words. These are written through a word-addressed port while a configuration-enable input is high. While loading is in progress, the outputs stay low.

Top module: `gen_logic_block`

## Requirements
- R1: A product term is the AND of literals chosen per input. Input i is controlled by the two bits [2i+1:2i] of the term's word. 00 drops the input from the term, 01 uses it true, 10 uses it complemented, and 11 forces the whole term to 0.
- R2: In the fast path of macrocell m, the output is the OR of terms 5m to 5m+3. The fifth term of the group (5m+4) is ignored, and there is no inversion.
- R3: In the wide path of macrocell m, the output ORs all five terms of every group g whose owner is m, then XORs the result with polarity bit 2N+m of the mode word (N=4). The owner of group g is (g + offset_g) mod 4. offset_g sits at mode bits [3N+2g+1 : 3N+2g], so group g defaults to macrocell g.
- R4: Mode bit N+m selects the wide path when set. Mode bit m selects registered output when set. A combinatorial output shows the logic value one clock after the inputs change.
- R5: A macrocell register loads only on a clock where the selected clock source is 1 after being 0 on the previous clock. A registered output shows the register one clock later. Holding the source high, or leaving it low, keeps the stored value.
- R6: Mode bits [3N+9:3N+8] (bits 21:20) select the register clock: 0, 1 and 2 pick global clocks 0 to 2, and 3 picks the clock product term at address 20. Clock lines that are not selected have no effect.
- R7: The reset product term (address 21) and a low level on the active-low global reset input each clear all macrocell registers at the next clock.
- R8: The output-enable product term (address 22) appears on the output-enable port one clock later.
- R9: Addresses 0 to 19 hold the shared terms, 20 to 22 the dedicated terms, and 23 the mode word. A word is stored only when configuration enable and write strobe are both high. A write strobe while configuration enable is low changes nothing.
- R10: While configuration enable is high, all outputs and output enable read 0 and the registers are cleared. The outputs are valid again one clock after configuration enable falls.
- R11: Synchronous reset sets every term word to all ones, so every term is forced to 0. It clears the mode word, the registers and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration load window |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_data | input | 36 | Configuration word |
| din | input | 18 | Logic inputs from the routing fabric |
| gclk | input | 3 | Global clock lines |
| glob_rst_n | input | 1 | Active-low global register clear |
| dout | output | 4 | Macrocell outputs, also fed back to the fabric |
| oe_out | output | 1 | Output enable for the I/O cells |

## Verification
A corrupted term word or mode field shows up on a combinatorial output one clock after the inputs that expose it are applied. Because of this, the input-vector table sweeps literals, polarity and group ownership together. A register that loads on the wrong clock source, or on a level rather than a rising edge, is visible at its output two clocks after the stray edge. Clear paths that are missing are visible one clock later still. A configuration store that accepts writes outside the load window is revealed by the next input pattern that reads the overwritten term.

// File: rtl/glb_pkg.sv
package glb_pkg;
  localparam int N_GCLK = 3;

  typedef enum logic [1:0] {
    LIT_SKIP = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_COMP = 2'b10,
    LIT_KILL = 2'b11
  } lit_e;

  typedef enum logic [1:0] {
    CSEL_G0 = 2'd0,
    CSEL_G1 = 2'd1,
    CSEL_G2 = 2'd2,
    CSEL_PT = 2'd3
  } csel_e;
endpackage

// File: rtl/glb_cfg_store.sv
module glb_cfg_store #(
  parameter int N_TW   = 23,
  parameter int CW     = 36,
  parameter int AW     = 5,
  parameter int MODE_W = 22
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_en,
  input  logic                     cfg_wr,
  input  logic [AW-1:0]            cfg_addr,
  input  logic [CW-1:0]            cfg_data,
  output logic [N_TW-1:0][CW-1:0]  term_cfg,
  output logic [MODE_W-1:0]        mode_q
);
  logic wr_ok;
  assign wr_ok = cfg_en & cfg_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < N_TW; w++) term_cfg[w] <= '1;
      mode_q <= '0;
    end else if (wr_ok) begin
      for (int w = 0; w < N_TW; w++)
        if (cfg_addr == AW'(w)) term_cfg[w] <= cfg_data;
      if (cfg_addr == AW'(N_TW)) mode_q <= cfg_data[MODE_W-1:0];
    end
  end
endmodule

// File: rtl/glb_pterm_array.sv
module glb_pterm_array
  import glb_pkg::*;
#(
  parameter int N_IN = 18,
  parameter int N_T  = 23,
  localparam int CW  = 2 * N_IN
) (
  input  logic [N_T-1:0][CW-1:0] cfg,
  input  logic [N_IN-1:0]        din,
  output logic [N_T-1:0]         pt
);
  for (genvar t = 0; t < N_T; t++) begin : g_term
    always_comb begin
      pt[t] = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        case (lit_e'(cfg[t][2*i +: 2]))
          LIT_TRUE: pt[t] = pt[t] & din[i];
          LIT_COMP: pt[t] = pt[t] & ~din[i];
          LIT_KILL: pt[t] = 1'b0;
          default:  pt[t] = pt[t];
        endcase
      end
    end
  end
endmodule

// File: rtl/glb_macrocell.sv
module glb_macrocell #(
  parameter int N_PT  = 20,
  parameter int G     = 5,
  parameter int N_BYP = 4,
  parameter int N_GRP = 4,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             clr,
  input  logic             tick,
  input  logic [N_PT-1:0]  pt,
  input  logic [N_GRP-1:0] own,
  input  logic             wide,
  input  logic             pol,
  input  logic             regd,
  output logic             q,
  output logic             dout
);
  logic byp, sum, d;

  always_comb begin
    byp = |pt[IDX*G +: N_BYP];
    sum = 1'b0;
    for (int g = 0; g < N_GRP; g++)
      sum = sum | (own[g] & (|pt[g*G +: G]));
    d = wide ? (sum ^ pol) : byp;
  end

  always_ff @(posedge clk) begin
    if (rst || hold || clr) q <= 1'b0;
    else if (tick)          q <= d;
  end

  always_ff @(posedge clk) begin
    if (rst || hold) dout <= 1'b0;
    else             dout <= regd ? q : d;
  end
endmodule

// File: rtl/gen_logic_block.sv
module gen_logic_block
  import glb_pkg::*;
#(
  parameter int N_IN      = 18,
  parameter int N_MC      = 4,
  parameter int PT_PER_MC = 5,
  parameter int N_BYP     = 4,
  localparam int N_PT     = N_MC * PT_PER_MC,
  localparam int CW       = 2 * N_IN,
  localparam int N_TW     = N_PT + 3,
  localparam int AW       = $clog2(N_TW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_wr,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CW-1:0]     cfg_data,
  input  logic [N_IN-1:0]   din,
  input  logic [N_GCLK-1:0] gclk,
  input  logic              glob_rst_n,
  output logic [N_MC-1:0]   dout,
  output logic              oe_out
);
  localparam int OW       = (N_MC > 1) ? $clog2(N_MC) : 1;
  localparam int WIDE_LSB = N_MC;
  localparam int POL_LSB  = 2 * N_MC;
  localparam int OFF_LSB  = 3 * N_MC;
  localparam int CSEL_LSB = OFF_LSB + OW * N_MC;
  localparam int MODE_W   = CSEL_LSB + 2;

  logic [N_TW-1:0][CW-1:0]  term_cfg;
  logic [MODE_W-1:0]        mode_q;
  logic [N_TW-1:0]          pt_all;
  logic [N_PT-1:0]          pt;
  logic                     pt_clk, pt_rst, pt_oe;
  logic                     src, src_q, tick, clr;
  logic [N_MC-1:0]          mc_q;
  logic [N_MC-1:0][N_MC-1:0] own;
  csel_e                    csel;

  glb_cfg_store #(.N_TW(N_TW), .CW(CW), .AW(AW), .MODE_W(MODE_W)) u_store (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .term_cfg(term_cfg), .mode_q(mode_q)
  );

  glb_pterm_array #(.N_IN(N_IN), .N_T(N_TW)) u_terms (
    .cfg(term_cfg), .din(din), .pt(pt_all)
  );

  assign pt     = pt_all[N_PT-1:0];
  assign pt_clk = pt_all[N_PT];
  assign pt_rst = pt_all[N_PT+1];
  assign pt_oe  = pt_all[N_PT+2];
  assign clr    = ~glob_rst_n | pt_rst;

  assign csel = csel_e'(mode_q[CSEL_LSB +: 2]);
  always_comb begin
    case (csel)
      CSEL_G0: src = gclk[0];
      CSEL_G1: src = gclk[1];
      CSEL_G2: src = gclk[2];
      default: src = pt_clk;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) src_q <= 1'b0;
    else     src_q <= src;
  end
  assign tick = src & ~src_q;

  always_ff @(posedge clk) begin
    if (rst || cfg_en) oe_out <= 1'b0;
    else               oe_out <= pt_oe;
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    for (genvar g = 0; g < N_MC; g++) begin : g_own
      assign own[m][g] = ((g + int'(mode_q[OFF_LSB + OW*g +: OW])) % N_MC) == m;
    end

    glb_macrocell #(
      .N_PT(N_PT), .G(PT_PER_MC), .N_BYP(N_BYP), .N_GRP(N_MC), .IDX(m)
    ) u_mc (
      .clk(clk), .rst(rst), .hold(cfg_en), .clr(clr), .tick(tick),
      .pt(pt), .own(own[m]),
      .wide(mode_q[WIDE_LSB + m]), .pol(mode_q[POL_LSB + m]),
      .regd(mode_q[m]),
      .q(mc_q[m]), .dout(dout[m])
    );
  end
endmodule

// File: rtl/glb_checker.sv
module glb_checker #(
  parameter int N_MC   = 4,
  parameter int MODE_W = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_en,
  input logic              glob_rst_n,
  input logic [N_MC-1:0]   dout,
  input logic [N_MC-1:0]   mc_q,
  input logic [N_MC-1:0]   reg_mask,
  input logic              oe_out,
  input logic [MODE_W-1:0] mode_q
);
  assert_blank_in_cfg_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (dout == '0 && !oe_out));

  assert_reset_defaults_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode_q == '0 && dout == '0 && !oe_out));

  assert_grst_clears_R7: assert property (@(posedge clk) disable iff (rst)
    !glob_rst_n |=> (mc_q == '0));

  assert_reg_output_R5: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (((dout ^ $past(mc_q)) & $past(reg_mask)) == '0));

  assert_mode_locked_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(mode_q));
endmodule

bind gen_logic_block glb_checker #(.N_MC(N_MC), .MODE_W(MODE_W)) u_glb_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .glob_rst_n(glob_rst_n),
  .dout(dout), .mc_q(mc_q), .reg_mask(mode_q[N_MC-1:0]),
  .oe_out(oe_out), .mode_q(mode_q)
);

// File: tb/gen_logic_block_test.sv
`timescale 1ns/1ps
module gen_logic_block_test;
  localparam int N_IN = 18;
  localparam int CW   = 36;
  localparam logic [35:0] MODE_BASE = 36'h102A4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_en = 1'b0, cfg_wr = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [CW-1:0] cfg_data = '0;
  logic [N_IN-1:0] din = '0;
  logic [2:0]  gclk = '0;
  logic        glob_rst_n = 1'b1;
  logic [3:0]  dout;
  logic        oe_out;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  gen_logic_block uut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .din(din), .gclk(gclk),
    .glob_rst_n(glob_rst_n), .dout(dout), .oe_out(oe_out)
  );

  // {din[9:0], expected {oe, d3, d2, d1, d0}}
  localparam logic [14:0] VECS [10] = '{
    {10'h000, 5'b00011}, {10'h004, 5'b00010}, {10'h007, 5'b00011},
    {10'h00C, 5'b00000}, {10'h014, 5'b01010}, {10'h024, 5'b01010},
    {10'h044, 5'b10010}, {10'h03D, 5'b01000}, {10'h06B, 5'b11001},
    {10'h204, 5'b00010}
  };

  function automatic logic [CW-1:0] lit(input int i, input logic [1:0] code);
    logic [CW-1:0] w = '0;
    w[2*i +: 2] = code;
    return w;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [CW-1:0] d);
    cfg_wr = 1'b1; cfg_addr = 5'(a); cfg_data = d;
    wait_n(1);
    cfg_wr = 1'b0;
  endtask

  task automatic set_mode(input logic [CW-1:0] m);
    cfg_en = 1'b1;
    put(23, m);
    cfg_en = 1'b0;
    wait_n(1);
  endtask

  initial begin : watchdog
    #800000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    din = '1;
    wait_n(3);
    rst = 1'b0;
    wait_n(2);
    check("R11 reset defaults", {3'b0, oe_out, dout}, 8'h00);

    cfg_en = 1'b1;
    put(0, lit(0, 2'b01) | lit(1, 2'b01));
    put(1, lit(2, 2'b10));
    put(4, lit(9, 2'b01));
    put(9, lit(3, 2'b01));
    put(10, lit(4, 2'b01));
    put(15, lit(5, 2'b01));
    put(20, lit(8, 2'b01));
    put(21, lit(7, 2'b01));
    put(22, lit(6, 2'b01));
    put(23, MODE_BASE);
    check("R10 outputs low while loading", {3'b0, oe_out, dout}, 8'h00);
    cfg_en = 1'b0;

    for (int k = 0; k < 10; k++) begin
      din = 18'(VECS[k][14:5]);
      wait_n(1);
      check($sformatf("R1/R2/R3/R4/R8 vector %0d", k),
            {3'b0, oe_out, dout}, {3'b0, VECS[k][4:0]});
    end

    din = 18'h010; wait_n(2);
    check("R5 no capture without edge", {7'b0, dout[2]}, 8'h00);
    gclk[1] = 1'b1; wait_n(2);
    check("R6 unselected clock ignored", {7'b0, dout[2]}, 8'h00);
    gclk[1] = 1'b0;
    gclk[0] = 1'b1; wait_n(2);
    check("R5 capture on rising source", {7'b0, dout[2]}, 8'h01);
    din = 18'h000; wait_n(2);
    check("R5 held while source stays high", {7'b0, dout[2]}, 8'h01);
    gclk[0] = 1'b0; wait_n(1);
    gclk[0] = 1'b1; wait_n(2);
    check("R5 second edge captures 0", {7'b0, dout[2]}, 8'h00);

    gclk[0] = 1'b0; din = 18'h010; wait_n(1);
    gclk[0] = 1'b1; wait_n(2);
    din = 18'h090; wait_n(2);
    check("R7 reset term clears register", {7'b0, dout[2]}, 8'h00);
    din = 18'h010; wait_n(2);
    check("R7 stays cleared without edge", {7'b0, dout[2]}, 8'h00);

    gclk[0] = 1'b0; wait_n(1);
    gclk[0] = 1'b1; wait_n(2);
    glob_rst_n = 1'b0; wait_n(1);
    glob_rst_n = 1'b1; wait_n(1);
    check("R7 global reset clears register", {7'b0, dout[2]}, 8'h00);
    gclk[0] = 1'b0;

    put(0, '0);
    din = 18'h004; wait_n(2);
    check("R9 write outside window ignored", {7'b0, dout[0]}, 8'h00);

    din = 18'h000;
    cfg_en = 1'b1; wait_n(2);
    check("R10 blank with enable high", {3'b0, oe_out, dout}, 8'h00);
    cfg_en = 1'b0; wait_n(1);
    check("R10 valid one clock after load", {3'b0, oe_out, dout}, 8'h03);

    set_mode(MODE_BASE | (36'd2 << 20));
    din = 18'h010; gclk[0] = 1'b1; wait_n(2);
    check("R6 global clock 0 deselected", {7'b0, dout[2]}, 8'h00);
    gclk[0] = 1'b0; gclk[2] = 1'b1; wait_n(2);
    check("R6 global clock 2 selected", {7'b0, dout[2]}, 8'h01);
    gclk[2] = 1'b0;

    set_mode(MODE_BASE | (36'd3 << 20));
    din = 18'h010; wait_n(2);
    check("R6 term clock idle", {7'b0, dout[2]}, 8'h00);
    din = 18'h110; wait_n(2);
    check("R6 term clock edge captures", {7'b0, dout[2]}, 8'h01);

    rst = 1'b1; wait_n(2);
    rst = 1'b0; din = '1; wait_n(2);
    check("R11 reset restores killed terms", {3'b0, oe_out, dout}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule